// File: doc/BRIEF.md
# Serial Management Bus Master

This block is the master side of a two-wire PHY management bus. It divides the system clock down to a management clock and shifts single frames out on a data line that both sides share. Software uses a four-entry register port. A configuration word picks the frame format, turns the preamble on or off and sets the clock divider. A command word names the operation, the PHY and the register or device, and writing it starts one frame. One data word supplies outgoing data. The other data word returns incoming data. Each data word also carries the progress flags for its kind of transfer.

Two frame formats are supported. The short-address format uses start code 01 and has only read and write. The extended-address format uses start code 00. It adds an address frame, and that frame takes its 16-bit register address from the outgoing data word. Reads release the line from the turnaround to the end of the frame. The bits sampled during that time become the returned data. A valid flag tells software when the returned data can be used.

Register map (word address on `wr_addr`/`rd_addr`):

- 0, configuration: bit 0 selects the extended format, bit 1 turns the preamble on, and bits [8 +: HALF_W] hold the half period in system clocks.
- 1, command: bits [1:0] hold the operation, bits [6:2] the PHY, bits [11:7] the register or device.
- 2, outgoing data: bits [15:0] hold the data, bit 16 is the write pending flag (read only).
- 3, returned data: bits [15:0] hold the data, bit 16 is the read pending flag, bit 17 is the valid flag (bits 16 and 17 read only).

Top module: `mdio_mgr`

## Requirements
- R1: After reset, word 0 reads short format, preamble on and half period DEF_HALF (0x402 with the defaults). Words 2 and 3 read 0. `mdc` is low and `mdio_oe` is low.
- R2: A frame of N bits keeps a pending flag set for 2·N·H system clocks, counted from the clock edge that takes the command, where H is the half period. In each bit, `mdc` is low for the first H clocks and high for the next H clocks. `mdc` stays low while no frame is running.
- R3: `mdio_o` and `mdio_oe` change only when `mdc` falls. Incoming data is sampled when `mdc` rises.
- R4: With the preamble on, a frame is 64 bits and starts with 32 ones. With the preamble off, a frame is the 32 bits that follow the preamble.
- R5: Short format, operation 0: the frame is start 01, opcode 01, PHY[4:0], register[4:0], turnaround 10, then the 16 bits of word 2, MSB first. The master drives every bit.
- R6: Short format, operation 1: the frame is start 01, opcode 10, PHY, register. The master then releases the line for the 18 remaining bits. The last 16 sampled bits appear in word 3 [15:0], and valid is set on the clock edge that ends the frame.
- R7: Extended format, operation 0: the frame is start 00, opcode 00, PHY, device, turnaround 10, then word 2 [15:0] as the register address.
- R8: Extended format, operation 1 sends opcode 01 with the word-2 data. Operations 3 and 2 are reads with opcode 11 and 10, and they release the line and return data as in R6.
- R9: Word 2 bit 16 is set exactly while a write or address frame runs. Word 3 bit 16 is set exactly while a read frame runs.
- R10: A command written while a frame runs is dropped. The running frame and its length are unchanged.
- R11: Launching a read clears valid on the launching edge.
- R12: Short format operations 2 and 3 start no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register word written |
| wr_data | input | DW | Write data |
| rd_addr | input | 2 | Register word read |
| rd_data | output | DW | Read data for `rd_addr` (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data driven onto the shared line |
| mdio_oe | output | 1 | Drive enable for the shared line |
| mdio_i | input | 1 | Line value seen at the pin |

## Verification
A behavioural PHY stub records every line bit and drive enable on each rising `mdc` edge. For read frames it drives the turnaround zero and a chosen 16-bit value. Frames are run in both formats with every meaningful operation code and with the preamble on and off. This separates start codes, opcode mapping, the source of the 16-bit field and where the line is released. Half periods of 4, 2 and 3 show that the divider is live. A command written mid-frame, the short-format codes 2 and 3, and two reads in a row with different values show dropped commands, rejected codes and the clearing of valid. The `mdc` level, the pending flags and valid are compared with a clocked reference model on every cycle.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int PRE_BITS  = 32;
   localparam int BODY_BITS = 32;
   localparam int FRAME_MAX = PRE_BITS + BODY_BITS;
   localparam int HDR_BITS  = 14;

   typedef enum logic [1:0] {
      A_CFG  = 2'd0,
      A_CMD  = 2'd1,
      A_WDAT = 2'd2,
      A_RDAT = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic [4:0] dev;
      logic [4:0] phy;
      logic [1:0] op;
   } cmd_t;

   // Frame body after the preamble: start, opcode, phy, dev, turnaround, data
   function automatic logic [BODY_BITS-1:0] frame_body(input logic c45, input cmd_t c,
                                                       input logic [15:0] d);
      logic [1:0] st;
      logic [1:0] wop;
      st  = c45 ? 2'b00 : 2'b01;
      wop = c45 ? c.op : (c.op[0] ? 2'b10 : 2'b01);
      return {st, wop, c.phy, c.dev, 2'b10, d};
   endfunction
endpackage

// File: rtl/mdio_tick.sv
module mdio_tick #(
   parameter int HALF_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [HALF_W-1:0] half,
   output logic              tick
);
   logic [HALF_W-1:0] cnt;
   logic [HALF_W-1:0] lim;

   assign lim  = (half == '0) ? '0 : half - HALF_W'(1);
   assign tick = run && (cnt >= lim);

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (!run || tick) cnt <= '0;
      else                 cnt <= cnt + HALF_W'(1);
   end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
   import mdio_pkg::*;
#(
   parameter int HALF_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              c45,
   input  logic              pre_en,
   input  logic              rd_op,
   input  cmd_t              cmd,
   input  logic [15:0]       wdata,
   input  logic [HALF_W-1:0] half,
   input  logic              mdio_i,
   output logic              busy,
   output logic              is_read,
   output logic              done,
   output logic [15:0]       rx,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe
);
   localparam int CNT_W = $clog2(FRAME_MAX + 1);

   logic [FRAME_MAX-1:0] tx, oe;
   logic [CNT_W-1:0]     left;
   logic                 tick;
   logic [BODY_BITS-1:0] body, obody;

   mdio_tick #(.HALF_W(HALF_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(busy), .half(half), .tick(tick)
   );

   assign body  = frame_body(c45, cmd, wdata);
   assign obody = rd_op ? {{HDR_BITS{1'b1}}, {(BODY_BITS-HDR_BITS){1'b0}}} : '1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0; is_read <= 1'b0; mdc <= 1'b0;
         tx <= '0; oe <= '0; left <= '0; rx <= '0;
      end else if (!busy) begin
         mdc <= 1'b0;
         if (start) begin
            busy    <= 1'b1;
            is_read <= rd_op;
            tx      <= pre_en ? {{PRE_BITS{1'b1}}, body}  : {body,  {PRE_BITS{1'b0}}};
            oe      <= pre_en ? {{PRE_BITS{1'b1}}, obody} : {obody, {PRE_BITS{1'b0}}};
            left    <= pre_en ? CNT_W'(FRAME_MAX) : CNT_W'(BODY_BITS);
         end
      end else if (tick) begin
         if (!mdc) begin
            mdc <= 1'b1;
            rx  <= {rx[14:0], mdio_i};
         end else begin
            mdc  <= 1'b0;
            tx   <= tx << 1;
            oe   <= oe << 1;
            left <= left - CNT_W'(1);
            if (left == CNT_W'(1)) busy <= 1'b0;
         end
      end
   end

   assign done    = busy && tick && mdc && (left == CNT_W'(1));
   assign mdio_o  = tx[FRAME_MAX-1];
   assign mdio_oe = busy && oe[FRAME_MAX-1];

   // R2
   mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe));
   // R3
   mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

// File: rtl/mdio_mgr.sv
module mdio_mgr
   import mdio_pkg::*;
#(
   parameter int DW       = 32,
   parameter int HALF_W   = 8,
   parameter int DEF_HALF = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [1:0]    rd_addr,
   output logic [DW-1:0] rd_data,
   output logic          mdc,
   output logic          mdio_o,
   output logic          mdio_oe,
   input  logic          mdio_i
);
   generate
      if (DW < 18 || DW < 8 + HALF_W) begin : g_dw_bad
         $error("mdio_mgr: DW too narrow for the register layout");
      end
      if (DEF_HALF < 1 || DEF_HALF >= (1 << HALF_W)) begin : g_half_bad
         $error("mdio_mgr: DEF_HALF out of range");
      end
   endgenerate

   logic              cfg_c45, cfg_pre;
   logic [HALF_W-1:0] cfg_half;
   cmd_t              cmd_q, new_cmd;
   logic [15:0]       wdat, rdat, rx;
   logic              rvalid, busy, is_read, done, launch, op_ok, rd_op;

   assign new_cmd = cmd_t'(wr_data[11:0]);
   assign op_ok   = cfg_c45 || !new_cmd.op[1];
   assign rd_op   = cfg_c45 ? new_cmd.op[1] : new_cmd.op[0];
   assign launch  = wr_en && (wr_addr == A_CMD) && !busy && op_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_c45 <= 1'b0; cfg_pre <= 1'b1; cfg_half <= HALF_W'(DEF_HALF);
         cmd_q <= '0; wdat <= '0; rdat <= '0; rvalid <= 1'b0;
      end else begin
         if (wr_en && wr_addr == A_CFG) begin
            cfg_c45  <= wr_data[0];
            cfg_pre  <= wr_data[1];
            cfg_half <= wr_data[8 +: HALF_W];
         end
         if (wr_en && wr_addr == A_WDAT) wdat <= wr_data[15:0];
         if (launch) begin
            cmd_q <= new_cmd;
            if (rd_op) rvalid <= 1'b0;
         end
         if (done && is_read) begin
            rdat   <= rx;
            rvalid <= 1'b1;
         end
      end
   end

   mdio_frame #(.HALF_W(HALF_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .start(launch), .c45(cfg_c45), .pre_en(cfg_pre),
      .rd_op(rd_op), .cmd(new_cmd), .wdata(wdat), .half(cfg_half), .mdio_i(mdio_i),
      .busy(busy), .is_read(is_read), .done(done), .rx(rx),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
   );

   always_comb begin
      case (rd_addr)
         A_CFG:   rd_data = DW'({cfg_half, 6'b0, cfg_pre, cfg_c45});
         A_CMD:   rd_data = DW'(cmd_q);
         A_WDAT:  rd_data = DW'({busy && !is_read, wdat});
         default: rd_data = DW'({rvalid, busy && is_read, rdat});
      endcase
   end

   // R11
   valid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && rd_op) |=> !rvalid);
   // R10
   cmd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_CMD && busy) |=> $stable(cmd_q));
   // R6
   valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rvalid) |-> $past(done && is_read));
endmodule

// File: tb/mdio_mgr_bench.sv
module mdio_mgr_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0, rd_addr = 2'd2;
   logic [31:0] wr_data = 32'd0;
   logic [31:0] rd_data;
   logic        mdc, mdio_o, mdio_oe, line;

   int n_chk = 0, n_fail = 0;
   bit fin = 1'b0;

   // PHY stub state
   int          n = 0;
   logic [63:0] cap = '0, oecap = '0;
   bit          s_rd = 0, s_drv = 0, s_val = 0;
   logic [15:0] rd_val = '0;

   // reference model state
   int m_c = 0, m_n = 64, m_h = 1, s_half = 4;
   bit m_busy = 0, m_read = 0, m_valid = 0, s_c45 = 0, s_pre_on = 1;
   logic prev_o = 1'b0;

   assign line = mdio_oe ? mdio_o : (s_drv ? s_val : 1'b1);

   mdio_mgr u_mdio_mgr (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
      .mdio_oe(mdio_oe), .mdio_i(line)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // stub: record on rising mdc, drive on falling mdc
   always @(posedge mdc) begin
      int pre;
      pre   = s_pre_on ? 32 : 0;
      cap   = {cap[62:0], line};
      oecap = {oecap[62:0], mdio_oe};
      n++;
      if (n == pre + 14)
         s_rd = (cap[13:12] == 2'b01 && cap[11:10] == 2'b10) || (cap[13:12] == 2'b00 && cap[11]);
   end

   always @(negedge mdc) begin
      int pre;
      pre = s_pre_on ? 32 : 0;
      if (s_rd && n == pre + 15) begin s_drv = 1; s_val = 0; end
      else if (s_rd && n >= pre + 16 && n < pre + 32) begin s_drv = 1; s_val = rd_val[15-(n-pre-16)]; end
      else s_drv = 0;
   end

   // reference model, advanced on every clock edge
   always @(posedge clk) begin
      bit was;
      if (rst_n) begin
         was = m_busy;
         if (m_busy) begin
            m_c++;
            if (m_c == 2*m_n*m_h) begin
               m_busy = 0;
               if (m_read) m_valid = 1;
            end
         end
         if (!was && wr_en && wr_addr == 2'd1 && (s_c45 || !wr_data[1])) begin
            m_busy = 1; m_c = 0; m_n = s_pre_on ? 64 : 32; m_h = s_half;
            m_read = s_c45 ? wr_data[1] : wr_data[0];
            if (m_read) m_valid = 0;
         end
         if (wr_en && wr_addr == 2'd0) begin
            s_c45 = wr_data[0]; s_pre_on = wr_data[1]; s_half = int'(wr_data[15:8]);
         end
      end
   end

   // per-clock comparison, away from the edge
   always @(posedge clk) begin
      bit em;
      #(CLK_PERIOD/4);
      if (rst_n && !fin) begin
         em = m_busy && ((m_c / m_h) % 2 == 1);
         chk(mdc === em, "R2 mdc level", 64'(mdc), 64'(em));
         if (rd_addr == 2'd2)
            chk(rd_data[16] === (m_busy && !m_read), "R9 write pending", 64'(rd_data[16]), 64'(m_busy && !m_read));
         else if (rd_addr == 2'd3) begin
            chk(rd_data[16] === (m_busy && m_read), "R9 read pending", 64'(rd_data[16]), 64'(m_busy && m_read));
            chk(rd_data[17] === m_valid, "R11 valid flag", 64'(rd_data[17]), 64'(m_valid));
         end
         if (mdc) chk(mdio_o === prev_o, "R3 mdio held while mdc high", 64'(mdio_o), 64'(prev_o));
         prev_o = mdio_o;
      end
   end

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      @(negedge clk); rd_addr = a; #1; v = rd_data;
   endtask

   function automatic logic [31:0] bdy(input bit c45, input logic [1:0] op, input logic [4:0] phy,
                                       input logic [4:0] dev, input logic [15:0] d);
      logic [1:0] wop;
      wop = c45 ? op : ((op == 2'd0) ? 2'b01 : 2'b10);
      return {(c45 ? 2'b00 : 2'b01), wop, phy, dev, 2'b10, d};
   endfunction

   task automatic launch(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] dev,
                         input bit rdf, input logic [15:0] rv);
      n = 0; cap = '0; oecap = '0; s_rd = 0; rd_val = rv;
      rd_addr = rdf ? 2'd3 : 2'd2;
      wr(2'd1, {20'd0, dev, phy, op});
   endtask

   task automatic finish(input logic [31:0] body, input bit rdf, input string tag);
      logic [63:0] ecap, eoe;
      logic [31:0] ob;
      int nb;
      while (m_busy) @(negedge clk);
      nb   = s_pre_on ? 64 : 32;
      ob   = rdf ? {14'h3FFF, 18'h0} : 32'hFFFF_FFFF;
      ecap = s_pre_on ? {32'hFFFF_FFFF, body} : {32'h0, body};
      eoe  = s_pre_on ? {32'hFFFF_FFFF, ob}   : {32'h0, ob};
      chk(n == nb, "R4 frame length", 64'(n), 64'(nb));
      chk(cap == ecap, tag, cap, ecap);
      chk(oecap == eoe, "R6 line release pattern", oecap, eoe);
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(2'd0, v); chk(v == 32'h402, "R1 config reset", 64'(v), 64'h402);
      rd(2'd2, v); chk(v == 32'h0, "R1 write word reset", 64'(v), 64'h0);
      rd(2'd3, v); chk(v == 32'h0, "R1 read word reset", 64'(v), 64'h0);
      chk(!mdc && !mdio_oe, "R1 idle line", 64'({mdc, mdio_oe}), 64'h0);

      // R5 short write with preamble, half 4
      wr(2'd2, 32'h0000_BEEF);
      launch(2'd0, 5'h11, 5'h0A, 0, 16'h0);
      finish(bdy(0, 2'd0, 5'h11, 5'h0A, 16'hBEEF), 0, "R5 short write frame");

      // R6 short read, half 2
      wr(2'd0, 32'h0000_0202);
      launch(2'd1, 5'h03, 5'h01, 1, 16'h5A3C);
      finish(bdy(0, 2'd1, 5'h03, 5'h01, 16'h5A3C), 1, "R6 short read frame");
      rd(2'd3, v); chk(v[17:0] == {2'b10, 16'h5A3C}, "R6 read data and valid", 64'(v[17:0]), 64'h25A3C);

      // R11 valid drops when the next read launches
      launch(2'd1, 5'h1F, 5'h1E, 1, 16'h0F0F);
      #1; chk(rd_data[17] == 1'b0, "R11 valid cleared at launch", 64'(rd_data[17]), 64'h0);
      finish(bdy(0, 2'd1, 5'h1F, 5'h1E, 16'h0F0F), 1, "R6 second read frame");
      rd(2'd3, v); chk(v[15:0] == 16'h0F0F, "R3 sampled data", 64'(v[15:0]), 64'h0F0F);

      // R7 extended address frame, preamble off
      wr(2'd0, 32'h0000_0201);
      wr(2'd2, 32'h0000_1234);
      launch(2'd0, 5'h07, 5'h03, 0, 16'h0);
      finish(bdy(1, 2'd0, 5'h07, 5'h03, 16'h1234), 0, "R7 address frame");

      // R8 extended write and reads
      wr(2'd2, 32'h0000_CAFE);
      launch(2'd1, 5'h07, 5'h03, 0, 16'h0);
      finish(bdy(1, 2'd1, 5'h07, 5'h03, 16'hCAFE), 0, "R8 extended write frame");
      launch(2'd3, 5'h07, 5'h03, 1, 16'h8001);
      finish(bdy(1, 2'd3, 5'h07, 5'h03, 16'h8001), 1, "R8 extended read frame");
      rd(2'd3, v); chk(v[17:0] == {2'b10, 16'h8001}, "R8 extended read data", 64'(v[17:0]), 64'h28001);
      launch(2'd2, 5'h02, 5'h04, 1, 16'h7E81);
      finish(bdy(1, 2'd2, 5'h02, 5'h04, 16'h7E81), 1, "R8 code 2 read frame");

      // R10 command during a running frame is dropped
      wr(2'd2, 32'h0000_A5A5);
      launch(2'd1, 5'h09, 5'h05, 0, 16'h0);
      repeat (40) @(negedge clk);
      wr(2'd1, {20'd0, 5'h1C, 5'h12, 2'd3});
      finish(bdy(1, 2'd1, 5'h09, 5'h05, 16'hA5A5), 0, "R10 frame unchanged by dropped command");
      rd(2'd1, v); chk(v[11:0] == {5'h05, 5'h09, 2'd1}, "R10 stored command kept", 64'(v[11:0]), 64'({5'h05, 5'h09, 2'd1}));

      // R12 short format codes 2 and 3 start nothing, half 3
      wr(2'd0, 32'h0000_0302);
      launch(2'd2, 5'h01, 5'h01, 0, 16'h0);
      repeat (20) @(negedge clk);
      chk(n == 0 && !mdc, "R12 code 2 ignored", 64'(n), 64'h0);
      launch(2'd3, 5'h01, 5'h01, 0, 16'h0);
      repeat (20) @(negedge clk);
      chk(n == 0 && !mdc, "R12 code 3 ignored", 64'(n), 64'h0);

      // R2 divider at half 3
      wr(2'd2, 32'h0000_0001);
      launch(2'd0, 5'h00, 5'h1F, 0, 16'h0);
      finish(bdy(0, 2'd0, 5'h00, 5'h1F, 16'h0001), 0, "R2 write frame at half 3");

      repeat (4) @(negedge clk);
      fin = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD*150000);
      if (!fin) begin
         fin = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule